// File: doc/BRIEF.md
# Receive Character Retiming Buffer

This block sits between the raw asynchronous bit stream of an FSK demodulator and a host that reads received data by clocking it out itself. The raw line is oversampled with the system clock. A start bit is recognised from a falling edge that is confirmed low at mid-bit. Eight data bits are then sampled at their centres, using a bit period given in system clock cycles, and the character is held in a small buffer.

When a character is held, the block pulls its active-low ready line low. The host answers with a train of rising edges on its read clock. Each edge moves the next stored bit onto the data output: first the start bit, then the data bits in the order they arrived. After the ninth edge, ready returns high and the buffer is free for the next character.

A host that keeps its read clock high for longer than a programmable number of cycles selects a pass-through mode. In that mode the synchronized raw stream drives the data output, ready stays high and no character is captured. Normal read pulses are shorter than this limit and never select the mode. If a new character completes while the previous one is still unread, a sticky flag records the overrun, the older character is kept and the newer one is dropped.

Top module: `rx_char_retimer`

## Requirements
- R1: A character is nine bits long: a start bit (line level 0) followed by eight data bits taken in arrival order. The idle and stop level of the line is 1.
- R2: `ready_n` goes to 0 once the eighth data bit of a character has been sampled, provided the buffer was empty when that happened.
- R3: While `ready_n` is 0, each rising edge of `host_clk` places the next stored bit on `data_out` within three system clock cycles. The first edge gives the start bit (0); edges two to nine give data bits one to eight in arrival order.
- R4: The ninth rising edge of `host_clk` returns `ready_n` to 1 and empties the buffer. A rising edge of `host_clk` while the buffer is empty leaves `data_out` unchanged.
- R5: If `host_clk` stays high for more than `bypass_limit` system cycles, the block enters pass-through. In pass-through, `data_out` follows `raw_in` two system cycles later, `ready_n` is 1, the buffer is emptied and no character is captured. Pass-through ends when `host_clk` goes low. Read pulses whose high time is at or below the limit never select pass-through.
- R6: A start bit is accepted only if the line is still 0 half a bit period after the falling edge. A low pulse shorter than that captures no character.
- R7: `bit_period` sets the number of system cycles per bit. The start bit is checked at half of that count after the falling edge, and each data bit is sampled one full period after the previous sample.
- R8: A character that completes while the buffer is full sets `overrun` to 1, and `overrun` stays 1 until reset. The buffered (older) character is kept unchanged and the new one is discarded.
- R9: After reset, `ready_n` is 1, `overrun` is 0 and `data_out` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for oversampling and all state |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_period | input | CNT_W | System clock cycles per received bit |
| bypass_limit | input | TMO_W | High time of host_clk, in cycles, beyond which pass-through is selected |
| raw_in | input | 1 | Raw asynchronous demodulator output |
| host_clk | input | 1 | Host read clock; each rising edge shifts out one bit; held high selects pass-through |
| data_out | output | 1 | Retimed bit, or synchronized raw stream in pass-through |
| ready_n | output | 1 | Active low: a complete character is waiting to be read |
| overrun | output | 1 | Sticky: a character was lost because the buffer was full |

## Verification
The `host_clk` input passes through two synchronizer flops and an edge detector before `data_out` is loaded, so a read result is due on the third system edge after the input changes. The bench holds each read clock level for twelve cycles and samples `data_out` on a falling edge near the end of the high phase, well after that point. In pass-through the raw line reaches `data_out` after two edges, and the bench samples four cycles after each change. Ready and overrun are checked only after a full stop bit and an idle bit have followed the last data bit, which is later than the data-bit centre plus the three-cycle pipeline. Reads are checked only after the ninth read clock's low phase has finished.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_START = 2'd1,
    FR_DATA  = 2'd2
  } fr_state_e;

endpackage

// File: rtl/rcr_sync.sv
module rcr_sync #(
  parameter int              WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= RST_VAL[i];
        sync_q[i] <= RST_VAL[i];
      end else begin
        meta_q[i] <= d[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/rcr_framer.sv
module rcr_framer
  import rcr_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int CNT_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 rx,
  input  logic [CNT_W-1:0]     bit_period,
  output logic                 char_valid,
  output logic [DATA_BITS-1:0] char_data
);

  localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

  fr_state_e            state_q, state_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [DATA_BITS-1:0] sh_q, sh_d;
  logic                 prev_q;
  logic                 valid_q, valid_d;
  logic [CNT_W-1:0]     half_cnt;

  assign half_cnt = bit_period >> 1;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    valid_d = 1'b0;
    if (clr) begin
      state_d = FR_IDLE;
      cnt_d   = '0;
      idx_d   = '0;
    end else begin
      case (state_q)
        FR_IDLE: begin
          if (prev_q && !rx) begin
            state_d = FR_START;
            cnt_d   = '0;
          end
        end
        FR_START: begin
          if (cnt_q == half_cnt - CNT_W'(1)) begin
            cnt_d = '0;
            idx_d = '0;
            if (!rx) state_d = FR_DATA;
            else     state_d = FR_IDLE;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        FR_DATA: begin
          if (cnt_q == bit_period - CNT_W'(1)) begin
            cnt_d = '0;
            sh_d  = {rx, sh_q[DATA_BITS-1:1]};
            if (idx_q == IDX_W'(DATA_BITS - 1)) begin
              valid_d = 1'b1;
              state_d = FR_IDLE;
            end else begin
              idx_d = idx_q + IDX_W'(1);
            end
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        default: state_d = FR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      prev_q  <= 1'b1;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      prev_q  <= rx;
      valid_q <= valid_d;
    end
  end

  assign char_valid = valid_q;
  assign char_data  = sh_q;

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R6
  start_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FR_START && !clr && cnt_q == half_cnt - CNT_W'(1) && rx) |=> (state_q == FR_IDLE));

endmodule

// File: rtl/rcr_char_buf.sv
module rcr_char_buf #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 load,
  input  logic [DATA_BITS-1:0] load_data,
  input  logic                 rd_rise,
  output logic                 full,
  output logic                 bit_out,
  output logic                 overrun
);

  localparam int CHAR_BITS = DATA_BITS + 1;
  localparam int PTR_W     = $clog2(CHAR_BITS);

  logic [CHAR_BITS-1:0] store_q, store_d;
  logic [PTR_W-1:0]     ptr_q, ptr_d;
  logic                 full_q, full_d;
  logic                 out_q, out_d;
  logic                 ovr_q, ovr_d;
  logic                 last_bit;

  assign last_bit = (ptr_q == PTR_W'(CHAR_BITS - 1));

  always_comb begin
    store_d = store_q;
    ptr_d   = ptr_q;
    full_d  = full_q;
    out_d   = out_q;
    ovr_d   = ovr_q;
    if (clr) begin
      full_d = 1'b0;
      ptr_d  = '0;
    end else begin
      if (full_q && rd_rise) begin
        out_d = store_q[ptr_q];
        if (last_bit) begin
          full_d = 1'b0;
          ptr_d  = '0;
        end else begin
          ptr_d = ptr_q + PTR_W'(1);
        end
      end
      if (load) begin
        if (!full_q) begin
          store_d = {load_data, 1'b0};
          full_d  = 1'b1;
          ptr_d   = '0;
        end else begin
          ovr_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
      ptr_q   <= '0;
      full_q  <= 1'b0;
      out_q   <= 1'b1;
      ovr_q   <= 1'b0;
    end else begin
      store_q <= store_d;
      ptr_q   <= ptr_d;
      full_q  <= full_d;
      out_q   <= out_d;
      ovr_q   <= ovr_d;
    end
  end

  assign full    = full_q;
  assign bit_out = out_q;
  assign overrun = ovr_q;

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q);

  // R8
  keep_older_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && full_q && !clr) |=> $stable(store_q));

  // R4
  empty_after_ninth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && full_q && last_bit) |=> !full_q);

  // R4
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && !full_q) |=> $stable(out_q));

endmodule

// File: rtl/rcr_mode_ctl.sv
module rcr_mode_ctl #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hclk,
  input  logic [TMO_W-1:0] limit,
  output logic             rd_rise,
  output logic             bypass
);

  logic             prev_q;
  logic [TMO_W-1:0] hcnt_q, hcnt_d;
  logic             byp_q, byp_d;
  logic             at_limit;

  assign at_limit = (hcnt_q == limit);

  always_comb begin
    hcnt_d = hcnt_q;
    byp_d  = byp_q;
    if (!hclk) begin
      hcnt_d = '0;
      byp_d  = 1'b0;
    end else begin
      if (!at_limit) hcnt_d = hcnt_q + TMO_W'(1);
      if (at_limit)  byp_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      hcnt_q <= '0;
      byp_q  <= 1'b0;
    end else begin
      prev_q <= hclk;
      hcnt_q <= hcnt_d;
      byp_q  <= byp_d;
    end
  end

  assign rd_rise = hclk && !prev_q;
  assign bypass  = byp_q;

  // R5
  leave_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hclk |=> !byp_q);

  // R5
  short_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!byp_q && !at_limit) |=> !byp_q);

endmodule

// File: rtl/rx_char_retimer.sv
module rx_char_retimer #(
  parameter int DATA_BITS = 8,
  parameter int CNT_W     = 16,
  parameter int TMO_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] bit_period,
  input  logic [TMO_W-1:0] bypass_limit,
  input  logic             raw_in,
  input  logic             host_clk,
  output logic             data_out,
  output logic             ready_n,
  output logic             overrun
);

  logic                 rst_meta_q, rst_n_i;
  logic [1:0]           sync_out;
  logic                 raw_s, hclk_s;
  logic                 rd_rise, bypass;
  logic                 char_valid;
  logic [DATA_BITS-1:0] char_data;
  logic                 buf_full, buf_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_i    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_i    <= rst_meta_q;
    end
  end

  rcr_sync #(.WIDTH(2), .RST_VAL(2'b10)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .d     ({raw_in, host_clk}),
    .q     (sync_out)
  );

  assign raw_s  = sync_out[1];
  assign hclk_s = sync_out[0];

  rcr_mode_ctl #(.TMO_W(TMO_W)) u_mode (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .hclk    (hclk_s),
    .limit   (bypass_limit),
    .rd_rise (rd_rise),
    .bypass  (bypass)
  );

  rcr_framer #(.DATA_BITS(DATA_BITS), .CNT_W(CNT_W)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .clr        (bypass),
    .rx         (raw_s),
    .bit_period (bit_period),
    .char_valid (char_valid),
    .char_data  (char_data)
  );

  rcr_char_buf #(.DATA_BITS(DATA_BITS)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .clr       (bypass),
    .load      (char_valid),
    .load_data (char_data),
    .rd_rise   (rd_rise),
    .full      (buf_full),
    .bit_out   (buf_bit),
    .overrun   (overrun)
  );

  assign ready_n  = !buf_full;
  assign data_out = bypass ? raw_s : buf_bit;

  // R5
  bypass_ready_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    bypass |=> ready_n);

  // R2
  ready_on_capture_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (char_valid && ready_n && !bypass) |=> !ready_n);

endmodule

// File: tb/tb_rx_char_retimer.sv
module tb_rx_char_retimer;

  logic        clk;
  logic        rst_n;
  logic [15:0] bit_period;
  logic [15:0] bypass_limit;
  logic        raw_in;
  logic        host_clk;
  logic        data_out;
  logic        ready_n;
  logic        overrun;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // {bit_period[15:0], character[7:0]}
  localparam int NVEC = 6;
  localparam logic [23:0] VEC [0:NVEC-1] = '{
    24'h0010A5, 24'h001000, 24'h0010FF,
    24'h00183C, 24'h001881, 24'h001C5A
  };

  rx_char_retimer dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_period   (bit_period),
    .bypass_limit (bypass_limit),
    .raw_in       (raw_in),
    .host_clk     (host_clk),
    .data_out     (data_out),
    .ready_n      (ready_n),
    .overrun      (overrun)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] ch);
    raw_in = 1'b0;
    wait_cyc(int'(bit_period));
    for (int i = 0; i < 8; i++) begin
      raw_in = ch[i];
      wait_cyc(int'(bit_period));
    end
    raw_in = 1'b1;
    wait_cyc(2 * int'(bit_period));
  endtask

  task automatic read_pulse(output logic b);
    host_clk = 1'b1;
    wait_cyc(12);
    b = data_out;
    host_clk = 1'b0;
    wait_cyc(12);
  endtask

  task automatic read_char(input logic [7:0] ch, input string tag);
    logic b;
    for (int i = 0; i < 9; i++) begin
      read_pulse(b);
      if (i == 0) chk({tag, " R3 start bit"}, b, 1'b0);
      else        chk({tag, " R3 R1 data bit"}, b, ch[i-1]);
    end
    chk({tag, " R4 ready_n high after ninth"}, ready_n, 1'b1);
  endtask

  initial begin
    logic b;
    rst_n        = 1'b0;
    bit_period   = 16'd16;
    bypass_limit = 16'd64;
    raw_in       = 1'b1;
    host_clk     = 1'b0;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);

    // R9 reset state
    chk("R9 ready_n", ready_n, 1'b1);
    chk("R9 overrun", overrun, 1'b0);
    chk("R9 data_out", data_out, 1'b1);

    // R1 R2 R3 R7 table walk
    for (int v = 0; v < NVEC; v++) begin
      bit_period = VEC[v][23:8];
      wait_cyc(2);
      send_char(VEC[v][7:0]);
      chk("R2 ready_n low after capture", ready_n, 1'b0);
      read_char(VEC[v][7:0], "R7 table");
      chk("R8 no overrun", overrun, 1'b0);
    end

    // R4 read edge on empty buffer keeps data_out (last bit of 0x5A is 0)
    read_pulse(b);
    chk("R4 idle read holds data_out", b, 1'b0);
    chk("R4 ready_n stays high", ready_n, 1'b1);

    // R6 short low glitch rejected
    bit_period = 16'd16;
    raw_in = 1'b0;
    wait_cyc(3);
    raw_in = 1'b1;
    wait_cyc(48);
    chk("R6 glitch not captured", ready_n, 1'b1);

    // R8 overrun keeps older character
    send_char(8'h96);
    send_char(8'h3E);
    chk("R8 overrun set", overrun, 1'b1);
    chk("R8 ready_n still low", ready_n, 1'b0);
    read_char(8'h96, "R8 older kept");
    chk("R8 overrun sticky", overrun, 1'b1);

    // R5 pass-through
    host_clk = 1'b1;
    wait_cyc(100);
    chk("R5 ready_n high in pass-through", ready_n, 1'b1);
    raw_in = 1'b0;
    wait_cyc(4);
    chk("R5 data_out follows raw low", data_out, 1'b0);
    raw_in = 1'b1;
    wait_cyc(4);
    chk("R5 data_out follows raw high", data_out, 1'b1);
    send_char(8'h55);
    chk("R5 no capture in pass-through", ready_n, 1'b1);
    host_clk = 1'b0;
    wait_cyc(12);
    chk("R5 buffer empty after exit", ready_n, 1'b1);
    send_char(8'hC3);
    chk("R5 normal mode resumes", ready_n, 1'b0);
    read_char(8'hC3, "R5 resume");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual hung expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule